// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the read path of a serial byte memory that answers as a slave on a two-wire clock/data bus. It watches the already-synchronised clock and data lines and detects Start, repeated Start and Stop. It takes a select byte and, for a dummy write, a two-byte address. It drives the data line only through an open-drain enable: when `sda_oe_o` is high, the line is pulled low.

Two storage areas sit behind one address counter. The main array holds 2^`MAIN_AW` bytes. At the default width this is 2 KB; a width of 13 gives 8 KB. The second area is a 32-byte identification page with its own device type code. Reading the page loads the shared counter, so a current address read of the main array that follows starts from the page offset. Both areas are behavioural register arrays, filled through a preload write port before use. Programming, write timing, page locking and write protect are not part of this block.

Top module: `eeprom_rd_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe_o`=0) and the shared address counter is 0.
- R2: The select byte is {type[7:4], chip[3:1], rw[0]}. Type 4'b1010 selects the main array and 4'b1011 selects the identification page. The slave acknowledges only when chip[3:1] equals `chip_sel_i` and the type is one of these two. Otherwise it does not acknowledge and ignores every bit until the next Start.
- R3: A random read is a select with rw=0, an address high byte, an address low byte, a repeated Start and a select with rw=1. It returns the byte at the address. The main array uses the low `MAIN_AW` address bits and ignores the rest.
- R4: A current address read is a Start and a select with rw=1. It returns the byte at the counter, and the counter then advances by one.
- R5: While the master acknowledges each byte, the slave keeps sending consecutive bytes. After a master not-acknowledge it leaves the data line released and sends nothing more.
- R6: On the main array the counter wraps from the last address to 0 during sequential reads.
- R7: On the identification page, address bits 4:0 pick the byte and bits 15:5 are ignored. Sequential reads wrap inside the 32 bytes.
- R8: An identification page access loads the counter with the page offset. The next main-array current read starts at that value.
- R9: The slave acknowledges by pulling the data line low during the ninth clock. It changes its drive only while the clock is low.
- R10: A Stop returns the slave to idle with the line released. A Start at any point, even inside a byte, restarts reception at the select byte. An aborted dummy write leaves the counter unchanged.
- R11: A preload write stores `pl_data_i` at `pl_addr_i`. It writes the identification page when `pl_id_i`=1 (low 5 bits) and the main array otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired line value) |
| chip_sel_i | input | 3 | Strapped chip-enable code matched against the select byte |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| pl_we_i | input | 1 | Preload write strobe |
| pl_id_i | input | 1 | Preload target: 1 identification page, 0 main array |
| pl_addr_i | input | MAIN_AW | Preload byte address |
| pl_data_i | input | 8 | Preload byte |

## Verification
The hardest state to reach from the ports is the one the shared counter is left in after an identification page read. That value is only visible through the first byte of the next main-array current read. The bench gets there with a directed page read that starts near the top of the page. This read wraps the page offset to a small value, and a main current read follows at once. A second hard case is an aborted transfer. A repeated Start is placed after a few bits of a select byte, and a Stop is placed halfway through an address byte. In each case a current read then confirms that the counter was neither reloaded nor advanced.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_DEVSEL, ST_ACK_DEV, ST_ADDR_HI, ST_ACK_HI,
      ST_ADDR_LO, ST_ACK_LO, ST_WAIT, ST_TX, ST_ACK_RX
   } rd_state_e;

   localparam logic [3:0] DEVTYPE_MAIN = 4'b1010;
   localparam logic [3:0] DEVTYPE_ID   = 4'b1011;
   localparam int         ID_AW        = 5;
endpackage

// File: rtl/eeprom_bus_cond.sv
module eeprom_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
   // data edge while the clock stays high marks a bus condition
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eeprom_rd_store.sv
module eeprom_rd_store #(
   parameter int MAIN_AW = 11,
   parameter int PAGE_AW = 5
) (
   input  logic               clk,
   input  logic               pl_we_i,
   input  logic               pl_id_i,
   input  logic [MAIN_AW-1:0] pl_addr_i,
   input  logic [7:0]         pl_data_i,
   input  logic               rd_id_i,
   input  logic [MAIN_AW-1:0] rd_addr_i,
   output logic [7:0]         rd_data_o
);
   localparam int MAIN_DEPTH = 1 << MAIN_AW;
   localparam int PAGE_DEPTH = 1 << PAGE_AW;

   logic [7:0] main_mem [MAIN_DEPTH];
   logic [7:0] page_mem [PAGE_DEPTH];

   always_ff @(posedge clk) begin
      if (pl_we_i) begin
         if (pl_id_i) page_mem[pl_addr_i[PAGE_AW-1:0]] <= pl_data_i;
         else         main_mem[pl_addr_i]              <= pl_data_i;
      end
   end

   assign rd_data_o = rd_id_i ? page_mem[rd_addr_i[PAGE_AW-1:0]] : main_mem[rd_addr_i];
endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
   parameter int MAIN_AW = 11,
   parameter int PAGE_AW = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               load_id_i,
   input  logic [MAIN_AW-1:0] load_val_i,
   input  logic               inc_i,
   input  logic               inc_id_i,
   output logic [MAIN_AW-1:0] ptr_o
);
   logic [MAIN_AW-1:0] nxt;

   generate
      if (MAIN_AW > PAGE_AW) begin : g_split
         // page increments keep the upper bits, array increments roll the full width
         assign nxt = inc_id_i ? {ptr_o[MAIN_AW-1:PAGE_AW], ptr_o[PAGE_AW-1:0] + PAGE_AW'(1)}
                               : ptr_o + MAIN_AW'(1);
      end else begin : g_flat
         assign nxt = ptr_o + MAIN_AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (load_i) ptr_o <= load_id_i ? MAIN_AW'(load_val_i[PAGE_AW-1:0]) : load_val_i;
      else if (inc_i)  ptr_o <= nxt;
   end
endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave #(
   parameter int MAIN_AW = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [2:0]         chip_sel_i,
   output logic               sda_oe_o,
   input  logic               pl_we_i,
   input  logic               pl_id_i,
   input  logic [MAIN_AW-1:0] pl_addr_i,
   input  logic [7:0]         pl_data_i
);
   import eeprom_rd_pkg::*;

   generate
      if (MAIN_AW < ID_AW || MAIN_AW > 16) begin : g_bad_aw
         $error("MAIN_AW must lie between the page width and 16");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;
   rd_state_e state;
   logic [3:0] bit_cnt;
   logic [7:0] shreg, tx_sh, addr_hi, rd_data;
   logic id_sel, rd_q, mst_ack;
   logic [MAIN_AW-1:0] ctr_ptr;
   logic ctr_load, ctr_inc, quiet, byte_in_done;
   logic [15:0] full_addr;
   logic unused_addr;

   eeprom_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det)
   );

   eeprom_rd_store #(.MAIN_AW(MAIN_AW), .PAGE_AW(ID_AW)) u_store (
      .clk(clk), .pl_we_i(pl_we_i), .pl_id_i(pl_id_i), .pl_addr_i(pl_addr_i),
      .pl_data_i(pl_data_i), .rd_id_i(id_sel), .rd_addr_i(ctr_ptr), .rd_data_o(rd_data)
   );

   assign quiet        = ~start_det & ~stop_det;
   assign byte_in_done = scl_fall && bit_cnt == 4'd8;
   assign full_addr    = {addr_hi, shreg};
   assign unused_addr  = ^full_addr;
   assign ctr_load     = quiet && state == ST_ADDR_LO && byte_in_done;
   assign ctr_inc      = quiet && state == ST_TX && scl_rise && bit_cnt == 4'd7;

   eeprom_addr_ctr #(.MAIN_AW(MAIN_AW), .PAGE_AW(ID_AW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load_i(ctr_load), .load_id_i(id_sel),
      .load_val_i(full_addr[MAIN_AW-1:0]), .inc_i(ctr_inc), .inc_id_i(id_sel),
      .ptr_o(ctr_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         tx_sh    <= '0;
         addr_hi  <= '0;
         id_sel   <= 1'b0;
         rd_q     <= 1'b0;
         mst_ack  <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_det) begin
         state    <= ST_DEVSEL;
         bit_cnt  <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         sda_oe_o <= 1'b0;
      end else begin
         case (state)
            ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO: begin
               if (scl_rise && bit_cnt < 4'd8) begin
                  shreg   <= {shreg[6:0], sda_i};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_in_done) begin
                  bit_cnt <= '0;
                  if (state == ST_DEVSEL) begin
                     if ((shreg[7:4] == DEVTYPE_MAIN || shreg[7:4] == DEVTYPE_ID) &&
                         shreg[3:1] == chip_sel_i) begin
                        id_sel   <= (shreg[7:4] == DEVTYPE_ID);
                        rd_q     <= shreg[0];
                        sda_oe_o <= 1'b1;
                        state    <= ST_ACK_DEV;
                     end else begin
                        state    <= ST_IDLE;
                     end
                  end else if (state == ST_ADDR_HI) begin
                     addr_hi  <= shreg;
                     sda_oe_o <= 1'b1;
                     state    <= ST_ACK_HI;
                  end else begin
                     sda_oe_o <= 1'b1;
                     state    <= ST_ACK_LO;
                  end
               end
            end
            ST_ACK_DEV: if (scl_fall) begin
               bit_cnt <= '0;
               if (rd_q) begin
                  tx_sh    <= rd_data;
                  sda_oe_o <= ~rd_data[7];
                  state    <= ST_TX;
               end else begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_ADDR_HI;
               end
            end
            ST_ACK_HI: if (scl_fall) begin
               sda_oe_o <= 1'b0;
               state    <= ST_ADDR_LO;
            end
            ST_ACK_LO: if (scl_fall) begin
               sda_oe_o <= 1'b0;
               state    <= ST_WAIT;
            end
            ST_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall) begin
                  if (bit_cnt == 4'd8) begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_ACK_RX;
                  end else begin
                     tx_sh    <= {tx_sh[6:0], 1'b0};
                     sda_oe_o <= ~tx_sh[6];
                  end
               end
            end
            ST_ACK_RX: begin
               if (scl_rise) begin
                  mst_ack <= ~sda_i;
               end else if (scl_fall) begin
                  bit_cnt <= '0;
                  if (mst_ack) begin
                     tx_sh    <= rd_data;
                     sda_oe_o <= ~rd_data[7];
                     state    <= ST_TX;
                  end else begin
                     state    <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/eeprom_rd_chk.sv
module eeprom_rd_chk #(
   parameter int MAIN_AW = 11
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        scl_i,
   input logic [2:0]                  chip_sel_i,
   input logic                        sda_oe_o,
   input logic                        start_i,
   input logic                        stop_i,
   input logic                        scl_fall_i,
   input eeprom_rd_pkg::rd_state_e    state_i,
   input logic [3:0]                  bit_cnt_i,
   input logic [7:0]                  shreg_i,
   input logic                        ctr_inc_i,
   input logic                        id_i,
   input logic [MAIN_AW-1:0]          ptr_i
);
   import eeprom_rd_pkg::*;

   // R9
   sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !$past(scl_i));

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!sda_oe_o && state_i == ST_IDLE));

   // R10
   start_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!sda_oe_o && state_i == ST_DEVSEL));

   // R2
   chip_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_DEVSEL && scl_fall_i && bit_cnt_i == 4'd8 &&
       shreg_i[3:1] != chip_sel_i && !start_i && !stop_i)
      |=> (!sda_oe_o && state_i == ST_IDLE));

   // R6
   array_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_inc_i && !id_i && ptr_i == '1) |=> ptr_i == '0);
endmodule

bind eeprom_rd_slave eeprom_rd_chk #(.MAIN_AW(MAIN_AW)) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .chip_sel_i(chip_sel_i),
   .sda_oe_o(sda_oe_o), .start_i(start_det), .stop_i(stop_det),
   .scl_fall_i(scl_fall), .state_i(state), .bit_cnt_i(bit_cnt),
   .shreg_i(shreg), .ctr_inc_i(ctr_inc), .id_i(id_sel), .ptr_i(ctr_ptr)
);

// File: tb/eeprom_rd_slave_tb_top.sv
module eeprom_rd_slave_tb_top;
   localparam int MAW   = 11;
   localparam int DEPTH = 1 << MAW;
   localparam int HQ    = 5;
   localparam logic [2:0] CE = 3'b101;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic m_scl, m_sda, sda_oe, sda_line;
   logic pl_we, pl_id;
   logic [MAW-1:0] pl_addr;
   logic [7:0] pl_data;
   logic [7:0] ref_main [DEPTH];
   logic [7:0] ref_id [32];
   logic [MAW-1:0] mdl_ctr;
   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   assign sda_line = m_sda & ~sda_oe;

   eeprom_rd_slave #(.MAIN_AW(MAW)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .chip_sel_i(CE), .sda_oe_o(sda_oe), .pl_we_i(pl_we), .pl_id_i(pl_id),
      .pl_addr_i(pl_addr), .pl_data_i(pl_data)
   );

   task automatic qwait();
      repeat (HQ) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sel(input bit idp, input bit rw);
      return {idp ? 4'b1011 : 4'b1010, CE, rw};
   endfunction

   function automatic logic [7:0] mdl_read(input bit idp);
      logic [7:0] d;
      if (idp) begin
         d = ref_id[mdl_ctr[4:0]];
         mdl_ctr[4:0] = mdl_ctr[4:0] + 5'd1;
      end else begin
         d = ref_main[mdl_ctr];
         mdl_ctr = mdl_ctr + 1'b1;
      end
      return d;
   endfunction

   task automatic bus_start();
      m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
      m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait();
      m_sda = 1'b1; qwait();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; qwait(); m_scl = 1'b1; qwait(); qwait(); m_scl = 1'b0; qwait();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
      ack = ~sda_line;
      qwait(); m_scl = 1'b0; qwait();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] d);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qwait(); m_scl = 1'b1; qwait();
         d[i] = sda_line;
         qwait(); m_scl = 1'b0;
      end
      qwait(); m_sda = ~give_ack; qwait(); m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0; qwait(); m_sda = 1'b1;
   endtask

   task automatic rd_bytes(input bit idp, input int n, input string req);
      logic [7:0] d, e;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, d);
         e = mdl_read(idp);
         chk(req, d, e);
      end
      qwait(); qwait();
      chk("R5 line released after NACK", sda_line, 1);
      bus_stop();
   endtask

   task automatic random_read(input bit idp, input logic [15:0] a, input int n, input string req);
      bit ack;
      bus_start();
      send_byte(sel(idp, 1'b0), ack); chk("R9 select ACK", ack, 1);
      send_byte(a[15:8], ack);        chk("R9 addr hi ACK", ack, 1);
      send_byte(a[7:0], ack);         chk("R9 addr lo ACK", ack, 1);
      mdl_ctr = idp ? MAW'(a[4:0]) : a[MAW-1:0];
      bus_start();
      send_byte(sel(idp, 1'b1), ack); chk("R3 read select ACK", ack, 1);
      rd_bytes(idp, n, req);
   endtask

   task automatic current_read(input bit idp, input int n, input string req);
      bit ack;
      bus_start();
      send_byte(sel(idp, 1'b1), ack); chk("R4 select ACK", ack, 1);
      rd_bytes(idp, n, req);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual %0d expected below 190000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit ack;
      void'($urandom(32'h5eed1234));
      m_scl = 1'b1; m_sda = 1'b1; pl_we = 1'b0; pl_id = 1'b0;
      pl_addr = '0; pl_data = '0; mdl_ctr = '0;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 line released after reset", sda_line, 1);

      // R11 preload both areas
      for (int i = 0; i < DEPTH + 32; i++) begin
         @(posedge clk); #1;
         pl_we   = 1'b1;
         pl_id   = (i >= DEPTH);
         pl_addr = MAW'(i >= DEPTH ? i - DEPTH : i);
         pl_data = 8'($urandom);
         if (i >= DEPTH) ref_id[i - DEPTH] = pl_data;
         else            ref_main[i]       = pl_data;
      end
      @(posedge clk); #1 pl_we = 1'b0;

      current_read(1'b0, 1, "R1 R11 counter starts at 0");
      random_read(1'b0, 16'hF123, 1, "R3 random read, upper bits ignored");
      current_read(1'b0, 2, "R4 current read continues");
      random_read(1'b0, 16'h0240, 5, "R5 sequential read");
      random_read(1'b0, 16'(DEPTH - 2), 4, "R6 wrap at array end");
      random_read(1'b1, 16'hFFFE, 4, "R7 page read wraps in 32");
      current_read(1'b0, 2, "R8 main read after page read");

      // R2 chip code mismatch, bad type, then a byte without Start
      bus_start();
      send_byte({4'b1010, ~CE, 1'b1}, ack); chk("R2 no ACK on chip mismatch", ack, 0);
      send_byte(sel(1'b0, 1'b1), ack);      chk("R2 ignored until Start", ack, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1100, CE, 1'b1}, ack);  chk("R2 no ACK on unknown type", ack, 0);
      bus_stop();

      // R10 Start inside a select byte, then Stop inside an address byte
      bus_start();
      send_bits(sel(1'b0, 1'b0), 4);
      bus_start();
      send_byte(sel(1'b0, 1'b0), ack);      chk("R10 resync after mid-byte Start", ack, 1);
      send_bits(8'h3C, 3);
      bus_stop();
      current_read(1'b0, 1, "R10 aborted write keeps counter");

      for (int it = 0; it < 14; it++) begin
         int op, n;
         op = int'($urandom % 3);
         n  = 1 + int'($urandom % 4);
         if (op == 0)      random_read(1'b0, 16'($urandom), n, "R3 random main");
         else if (op == 1) random_read(1'b1, 16'($urandom), n, "R7 random page");
         else              current_read(1'b0, n, "R4 random current");
      end

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule